// File: doc/BRIEF.md
# Fractional Microsecond Timebase

This block turns a fast reference clock into a steady one-microsecond tick and counts those ticks in a free-running 32-bit counter. The reference frequency does not need to be an integer number of megahertz. Software programs a rational ratio: M ticks for every N reference clocks, each field stored as its value minus one. A phase accumulator spreads the M ticks evenly over the N clocks. With the right ratio, a 12.8 MHz or 38.4 MHz reference gives exactly one tick per microsecond on average.

Software reaches the block through a simple register port. It can program the ratio, read the counter and freeze the timebase. Reads are returned one cycle after the request, flagged by a valid strobe. The read return has no ready signal and cannot be stalled: the requester must take the data in the cycle its valid strobe is high. A one-cycle tick pulse is also brought out for local consumers.

Top module: `ustb_timebase`

## Requirements
- R1: After reset, the counter is 0, the freeze bit is 0, and the ratio register holds RST_CFG (default 0x000B, one tick per twelve clocks).
- R2: The ratio register sits at offset 0x14. Bits [7:0] hold N-1, where N is the number of reference clocks. Bits [15:8] hold M-1, where M is the number of ticks per N clocks. So a stored 0 means 1, and 0x043F means 5 ticks per 64 clocks.
- R3: On every enabled clock the accumulator adds M. When the sum reaches N or more, N is subtracted and one tick is produced in that cycle. The k-th enabled clock after the accumulator is cleared therefore ends with floor(k*M/N) ticks in total.
- R4: The counter is read at offset 0x10. It rises by exactly one for each tick, never changes without a tick, and wraps from all-ones to zero.
- R5: Bit 0 at offset 0x4C is the freeze bit. While it is 1, no ticks occur and both the counter and the accumulator hold their values. The freeze bit reads back at the same offset.
- R6: A write to the ratio register clears the accumulator. No tick is produced in the cycle of that write.
- R7: If M is greater than N, exactly one tick is produced per enabled clock. The accumulator is then held at N-1.
- R8: A read returns its data one cycle after the request, with bus_rvalid high for one cycle. A read of an unmapped offset returns 0. Writes to the counter offset or to unmapped offsets change nothing.
- R9: us_tick is high for one cycle exactly when the counter steps on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read request |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | One-cycle read-return strobe, no back-pressure |
| us_tick | output | 1 | One-cycle microsecond tick pulse |
| us_count | output | CNT_W | Live microsecond count |

## Verification
The hardest case to reach from the ports is the counter wrap. At one tick per microsecond, a 32-bit counter would need billions of cycles to get there. The bench therefore adds a second instance with an 8-bit counter, reset into the 1/1 ratio so that it ticks on every clock. That instance passes its wrap point within a few hundred cycles, and its count is compared against a count of reset-released edges taken modulo 256. The second hard case is the n+1 ratio corner where M exceeds N. It is reached by writing 0x0500, which sets M to 6 and N to 1.

// File: rtl/ustb_pkg.sv
package ustb_pkg;
  localparam int FIELD_W = 8;
  localparam int ACC_W   = FIELD_W + 1;

  typedef struct packed {
    logic [FIELD_W-1:0] mul_m1;  // ticks per period, minus one
    logic [FIELD_W-1:0] div_m1;  // reference clocks per period, minus one
  } ratio_cfg_t;
endpackage

// File: rtl/ustb_regs.sv
module ustb_regs
  import ustb_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int          DATA_W   = 32,
  parameter int          CNT_W    = 32,
  parameter logic [15:0] RST_CFG  = 16'h000B,
  parameter int          OFF_CNT  = 'h10,
  parameter int          OFF_CFG  = 'h14,
  parameter int          OFF_FRZ  = 'h4C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd,
  input  logic [CNT_W-1:0]  cnt_val,
  output ratio_cfg_t        cfg,
  output logic              frz,
  output logic              cfg_wr,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  localparam int CFG_W = 2 * FIELD_W;

  logic              hit_cnt, hit_cfg, hit_frz;
  logic [DATA_W-1:0] rmux;

  assign hit_cnt = (addr == ADDR_W'(OFF_CNT));
  assign hit_cfg = (addr == ADDR_W'(OFF_CFG));
  assign hit_frz = (addr == ADDR_W'(OFF_FRZ));
  assign cfg_wr  = wr && hit_cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= ratio_cfg_t'(RST_CFG);
      frz <= 1'b0;
    end else begin
      if (cfg_wr)         cfg <= ratio_cfg_t'(wdata[CFG_W-1:0]);
      if (wr && hit_frz)  frz <= wdata[0];
    end
  end

  always_comb begin
    rmux = '0;
    if (hit_cnt)      rmux = DATA_W'(cnt_val);
    else if (hit_cfg) rmux = DATA_W'(cfg);
    else if (hit_frz) rmux = DATA_W'(frz);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd;
      if (rd) rdata <= rmux;
    end
  end
endmodule

// File: rtl/ustb_ratio_acc.sv
module ustb_ratio_acc
  import ustb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  ratio_cfg_t       cfg,
  input  logic             clr,
  input  logic             hold,
  output logic             tick,
  output logic [ACC_W-1:0] acc
);
  logic [ACC_W:0]   mul_v, div_v, sum, rem;
  logic [ACC_W-1:0] nxt;
  logic             reach;

  assign mul_v = (ACC_W+1)'(cfg.mul_m1) + 1'b1;
  assign div_v = (ACC_W+1)'(cfg.div_m1) + 1'b1;
  assign sum   = (ACC_W+1)'(acc) + mul_v;
  assign reach = (sum >= div_v);
  assign rem   = sum - div_v;
  assign tick  = !hold && !clr && reach;

  always_comb begin
    if (!reach)            nxt = ACC_W'(sum);
    else if (rem >= div_v) nxt = ACC_W'(div_v - 1'b1);  // M > N: clamp
    else                   nxt = ACC_W'(rem);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc <= '0;
    else if (clr)   acc <= '0;
    else if (!hold) acc <= nxt;
  end
endmodule

// File: rtl/ustb_count.sv
module ustb_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (step) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ustb_timebase.sv
module ustb_timebase
  import ustb_pkg::*;
#(
  parameter int          CNT_W   = 32,
  parameter logic [15:0] RST_CFG = 16'h000B
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       bus_addr,
  input  logic             bus_wr,
  input  logic [31:0]      bus_wdata,
  input  logic             bus_rd,
  output logic [31:0]      bus_rdata,
  output logic             bus_rvalid,
  output logic             us_tick,
  output logic [CNT_W-1:0] us_count
);
  ratio_cfg_t       cfg_w;
  logic             frz_q;
  logic             cfg_wr;
  logic [ACC_W-1:0] acc_q;

  ustb_regs #(
    .ADDR_W(8), .DATA_W(32), .CNT_W(CNT_W), .RST_CFG(RST_CFG)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr),
    .wdata(bus_wdata), .rd(bus_rd), .cnt_val(us_count),
    .cfg(cfg_w), .frz(frz_q), .cfg_wr(cfg_wr),
    .rdata(bus_rdata), .rvalid(bus_rvalid)
  );

  ustb_ratio_acc acc_i (
    .clk(clk), .rst_n(rst_n), .cfg(cfg_w), .clr(cfg_wr),
    .hold(frz_q), .tick(us_tick), .acc(acc_q)
  );

  ustb_count #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .step(us_tick), .cnt(us_count)
  );
endmodule

// File: rtl/ustb_checker.sv
module ustb_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [15:0]      cfg,
  input logic             frz_q,
  input logic             cfg_wr,
  input logic [8:0]       acc_q,
  input logic             us_tick,
  input logic [CNT_W-1:0] us_count
);
  a_r3_acc_below_n: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q <= {1'b0, cfg[7:0]});

  a_r9_tick_steps: assert property (@(posedge clk) disable iff (!rst_n)
    us_tick |=> us_count == CNT_W'($past(us_count) + 1'b1));

  a_r4_no_silent_step: assert property (@(posedge clk) disable iff (!rst_n)
    !us_tick |=> $stable(us_count));

  a_r5_freeze_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_q && !cfg_wr) |=> ($stable(acc_q) && $stable(us_count)));

  a_r6_cfg_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> acc_q == '0);

  a_r6_no_tick_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |-> !us_tick);
endmodule

bind ustb_timebase ustb_checker #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg(cfg_w), .frz_q(frz_q), .cfg_wr(cfg_wr),
  .acc_q(acc_q), .us_tick(us_tick), .us_count(us_count)
);

// File: tb/ustb_timebase_tb_top.sv
module ustb_timebase_tb_top;
  localparam logic [7:0] A_CNT = 8'h10, A_CFG = 8'h14, A_FRZ = 8'h4C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid, us_tick;
  logic [31:0] us_count;

  logic [31:0] w_rdata;
  logic        w_rvalid, w_tick;
  logic [7:0]  w_count;

  int checks = 0, fails = 0;
  string cur_tag = "";

  typedef struct { logic [31:0] v; string tag; } exp_t;
  exp_t sbq[$];

  always #2.5 clk = ~clk;

  ustb_timebase #(.CNT_W(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .us_tick(us_tick), .us_count(us_count)
  );

  // Narrow instance at 1/1 ratio for the wrap case
  ustb_timebase #(.CNT_W(8), .RST_CFG(16'h0000)) dut_w (
    .clk(clk), .rst_n(rst_n), .bus_addr(8'h00), .bus_wr(1'b0),
    .bus_wdata(32'h0), .bus_rd(1'b0), .bus_rdata(w_rdata),
    .bus_rvalid(w_rvalid), .us_tick(w_tick), .us_count(w_count)
  );

  // Reference model from the requirements
  logic [15:0] m_cfg = 16'h000B;
  logic        m_frz = 1'b0;
  int          m_acc = 0;
  logic [31:0] m_cnt = '0;
  int          edges = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      int mm, nn, s;
      logic tk, cw;
      edges++;
      if (bus_rd) begin
        exp_t e;
        e.tag = cur_tag;
        case (bus_addr)
          A_CNT:   e.v = m_cnt;
          A_CFG:   e.v = {16'h0, m_cfg};
          A_FRZ:   e.v = {31'h0, m_frz};
          default: e.v = '0;
        endcase
        sbq.push_back(e);
      end
      mm = int'(m_cfg[15:8]) + 1;
      nn = int'(m_cfg[7:0]) + 1;
      s  = m_acc + mm;
      cw = bus_wr && (bus_addr == A_CFG);
      tk = !m_frz && !cw && (s >= nn);
      if (cw) begin
        m_cfg = bus_wdata[15:0];
        m_acc = 0;
      end else if (!m_frz) begin
        if (s < nn) m_acc = s;
        else if (s - nn >= nn) m_acc = nn - 1;
        else m_acc = s - nn;
      end
      if (tk) m_cnt = m_cnt + 1;
      if (bus_wr && bus_addr == A_FRZ) m_frz = bus_wdata[0];
    end
  end

  // Monitor: pop and compare read returns
  always @(negedge clk) begin
    if (bus_rvalid) begin
      checks++;
      if (sbq.size() == 0) begin
        fails++;
        $display("FAIL %s: unexpected read return actual=%h expected=none", cur_tag, bus_rdata);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        if (bus_rdata !== e.v) begin
          fails++;
          $display("FAIL %s: actual=%h expected=%h", e.tag, bus_rdata, e.v);
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    @(negedge clk);
    cur_tag = tag; bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk_w(input string tag);
    checks++;
    if (w_count !== 8'(edges)) begin
      fails++;
      $display("FAIL %s: narrow count actual=%0d expected=%0d", tag, w_count, 8'(edges));
    end
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    checks++;
    if (us_count !== 32'h0) begin
      fails++;
      $display("FAIL R1: us_count actual=%h expected=0", us_count);
    end
    rd(A_CNT, "R1_cnt");
    rd(A_CFG, "R1_cfg");
    rd(A_FRZ, "R1_frz");
    idle(120);
    rd(A_CNT, "R4_count_12to1");
    wr(A_CFG, 32'h0000_043F);
    rd(A_CFG, "R2_cfg_readback");
    idle(128);
    rd(A_CNT, "R3_ratio_5_per_64");
    wr(A_CFG, 32'h0000_045F);
    idle(197);
    rd(A_CNT, "R3_ratio_5_per_96");
    wr(A_FRZ, 32'h1);
    rd(A_FRZ, "R5_frz_readback");
    rd(A_CNT, "R5_frozen_a");
    idle(60);
    rd(A_CNT, "R5_frozen_b");
    wr(A_FRZ, 32'h0);
    idle(41);
    rd(A_CNT, "R5_resume");
    wr(A_CFG, 32'h0000_000B);
    wr(A_CFG, 32'h0000_000B);
    idle(5);
    rd(A_CNT, "R6_cfg_clear");
    wr(A_CNT, 32'h0000_1234);
    rd(A_CNT, "R8_cnt_write_ignored");
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, "R8_unmapped_zero");
    rd(A_CFG, "R8_cfg_untouched");
    wr(A_CFG, 32'h0000_0500);
    idle(20);
    rd(A_CNT, "R7_m_gt_n");
    idle(2);
    chk_w("R4_wrap_a");
    idle(300 - edges);
    chk_w("R4_wrap_b");
    idle(4);
    checks++;
    if (sbq.size() != 0) begin
      fails++;
      $display("FAIL R8: pending reads actual=%0d expected=0", sbq.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule